// File: doc/BRIEF.md
# Stipple and block-copy raster engine

This block is a write-driven drawing accelerator for a framebuffer of 2^20 pixels. Every pixel lives in three planes: an 8-bit index plane, a 24-bit colour plane and a 32-bit control plane that carries the per-pixel mode bits. Software starts an operation with two 32-bit writes. The first write loads a word into the colour latch. The second write gives the destination pixel through its address and the command through its data. The engine then walks the target pixels one at a time through a synchronous framebuffer port.

Two operations exist. A stipple expands a 32-bit mask into colour fills of single pixels. A blit either copies a run of 1 to 32 pixels from a source index or, when the source field is all ones, fills the run with the latched colour. Each operation has a plain variant and a raw variant. They differ only in whether the control plane is written. The 24-bit depth input decides whether the colour plane is written at all. The engine raises busy while it works, and it holds off further writes with a ready signal.

Top module: `rast_engine`

## Requirements
- R1: A write accepted with wr_addr bit 2 clear stores wr_data in the colour latch. It starts no memory access and leaves busy low.
- R2: A write accepted with wr_addr bit 2 set starts an operation. The destination pixel index is wr_addr[22:3]. Busy is high from the next cycle until the last pixel step. While busy, wr_ready is low and any pending write is stalled until the engine is idle again.
- R3: A stipple (wr_blit low) scans the mask in wr_data from bit 31 down to bit 0. Bit 31 maps to destination+0 and bit 0 maps to destination+31. Each set bit writes the latched colour to its pixel, one pixel address per cycle. Clear bits leave their pixels unchanged.
- R4: A blit (wr_blit high) takes its source pixel index from wr_data[19:0] of the 24-bit field wr_data[23:0], and its run length from wr_data[28:24] plus one, giving 1 to 32 pixels. Bits 31:29 are ignored.
- R5: A blit whose wr_data[23:0] equals 24'hFFFFFF is a fill. Each pixel of the run receives the latched colour.
- R6: Any other blit copies the run in increasing pixel order. Each source pixel is read before its destination pixel is written, so a forward overlapping copy (destination = source + 1) replicates the first source pixel across the run.
- R7: Every pixel write updates the 8-bit plane, with the colour's low byte or the copied byte. With depth24 low, the 24-bit and control planes are never written.
- R8: With depth24 high, every pixel write also updates the 24-bit plane, with colour[23:0] or the copied 24-bit value.
- R9: A raw variant (wr_raw high) with depth24 high also writes the control plane, with the full 32-bit latched word or the copied control word. Plain variants never write the control plane.
- R10: Destination and source indices advance modulo 2^20, so a run that passes pixel 0xFFFFF continues at pixel 0.
- R11: Busy lasts 32 cycles for a stipple, len cycles for a fill and 2*len cycles for a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Engine can accept a write this cycle |
| wr_addr | input | 23 | Write byte address within the accelerator window |
| wr_data | input | 32 | Write data word |
| wr_blit | input | 1 | Selects the blit window (high) or the stipple window (low) |
| wr_raw | input | 1 | Selects the raw window, which also writes the control plane |
| depth24 | input | 1 | 24-bit depth mode, captured when an operation starts |
| busy | output | 1 | Operation in progress |
| mem_addr | output | 20 | Framebuffer pixel index |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_rd8 | input | 8 | Read data, 8-bit plane |
| mem_rd24 | input | 24 | Read data, 24-bit plane |
| mem_rdctl | input | 32 | Read data, control plane |
| mem_we8 | output | 1 | Write enable, 8-bit plane |
| mem_we24 | output | 1 | Write enable, 24-bit plane |
| mem_wectl | output | 1 | Write enable, control plane |
| mem_wd8 | output | 8 | Write data, 8-bit plane |
| mem_wd24 | output | 24 | Write data, 24-bit plane |
| mem_wdctl | output | 32 | Write data, control plane |

## Verification
Stipple masks range from single end bits (0x80000001) through all ones to random words. These tell a correct bit-to-pixel order apart from a reversed one, and they show that clear bits leave pixels untouched. Blits are tried as fills of length 1 and 32, as disjoint copies and as a forward copy overlapping by one pixel. The overlapping copy separates a read-then-write step from a batched or reversed one. Each shape is run in both depth modes and in both variants, so that plane gating is exposed. A run that crosses pixel 0xFFFFF checks the index wrap. A write issued during an operation checks the stall.

// File: rtl/rast_pkg.sv
package rast_pkg;
    parameter int PIX_AW   = 20;
    parameter int WORD_W   = 32;
    parameter int RUN_W    = 5;
    parameter int CNT_W    = RUN_W + 1;
    parameter int SRC_W    = 24;
    parameter int C24_W    = 24;
    parameter int C8_W     = 8;
    parameter int ADDR_LSB = 3;
    parameter int ADDR_W   = PIX_AW + ADDR_LSB;
    parameter int TRIG_BIT = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_STIP,
        PH_FILL,
        PH_CPRD,
        PH_CPWR
    } phase_e;

    typedef struct packed {
        logic              is_blit;
        logic              is_raw;
        logic              is_fill;
        logic              deep;
        logic [PIX_AW-1:0] dst;
        logic [PIX_AW-1:0] src;
        logic [CNT_W-1:0]  len;
        logic [WORD_W-1:0] word;
    } cmd_t;
endpackage

// File: rtl/rast_cmd_decode.sv
module rast_cmd_decode
    import rast_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    input  logic              blit,
    input  logic              raw,
    input  logic              deep,
    output cmd_t              cmd
);
    always_comb begin
        cmd.is_blit = blit;
        cmd.is_raw  = raw;
        cmd.is_fill = blit && (data[SRC_W-1:0] == {SRC_W{1'b1}});
        cmd.deep    = deep;
        cmd.dst     = addr[ADDR_LSB +: PIX_AW];
        cmd.src     = data[PIX_AW-1:0];
        cmd.len     = {1'b0, data[SRC_W +: RUN_W]} + CNT_W'(1);
        cmd.word    = data;
    end
endmodule

// File: rtl/rast_seq.sv
module rast_seq
    import rast_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              wr_trig,
    input  logic [WORD_W-1:0] wr_data,
    input  cmd_t              cmd_in,
    output logic              ready,
    output logic              busy,
    output logic [PIX_AW-1:0] pix_addr,
    output logic              pix_we,
    output logic              pix_rd,
    output logic              pix_copy,
    output logic              op_raw,
    output logic              op_deep,
    output logic [WORD_W-1:0] colour
);
    typedef struct packed {
        phase_e            ph;
        cmd_t              cmd;
        logic [WORD_W-1:0] colour;
        logic [CNT_W-1:0]  idx;
    } seq_t;

    localparam logic [CNT_W-1:0] STIP_LAST = CNT_W'(WORD_W - 1);

    seq_t cur_q, nxt_d;
    logic last_run;

    always_comb begin
        nxt_d    = cur_q;
        ready    = (cur_q.ph == PH_IDLE);
        busy     = !ready;
        pix_addr = cur_q.cmd.dst + PIX_AW'(cur_q.idx);
        pix_we   = 1'b0;
        pix_rd   = 1'b0;
        pix_copy = 1'b0;
        last_run = (cur_q.idx == cur_q.cmd.len - CNT_W'(1));
        case (cur_q.ph)
            PH_IDLE: begin
                if (wr_fire) begin
                    if (!wr_trig) begin
                        nxt_d.colour = wr_data;
                    end else begin
                        nxt_d.cmd = cmd_in;
                        nxt_d.idx = '0;
                        if (!cmd_in.is_blit)     nxt_d.ph = PH_STIP;
                        else if (cmd_in.is_fill) nxt_d.ph = PH_FILL;
                        else                     nxt_d.ph = PH_CPRD;
                    end
                end
            end
            PH_STIP: begin
                pix_we         = cur_q.cmd.word[WORD_W-1];
                nxt_d.cmd.word = cur_q.cmd.word << 1;
                nxt_d.idx      = cur_q.idx + CNT_W'(1);
                if (cur_q.idx == STIP_LAST) nxt_d.ph = PH_IDLE;
            end
            PH_FILL: begin
                pix_we    = 1'b1;
                nxt_d.idx = cur_q.idx + CNT_W'(1);
                if (last_run) nxt_d.ph = PH_IDLE;
            end
            PH_CPRD: begin
                pix_rd   = 1'b1;
                pix_addr = cur_q.cmd.src + PIX_AW'(cur_q.idx);
                nxt_d.ph = PH_CPWR;
            end
            PH_CPWR: begin
                pix_we   = 1'b1;
                pix_copy = 1'b1;
                if (last_run) begin
                    nxt_d.ph = PH_IDLE;
                end else begin
                    nxt_d.idx = cur_q.idx + CNT_W'(1);
                    nxt_d.ph  = PH_CPRD;
                end
            end
            default: nxt_d.ph = PH_IDLE;
        endcase
    end

    assign op_raw  = cur_q.cmd.is_raw;
    assign op_deep = cur_q.cmd.deep;
    assign colour  = cur_q.colour;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assert_copy_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rd |=> (pix_we && pix_copy));

    assert_colour_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(colour));

    assert_stip_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == PH_STIP && $past(cur_q.ph) == PH_STIP)
            |-> pix_addr == $past(pix_addr) + PIX_AW'(1));
endmodule

// File: rtl/rast_plane_wr.sv
module rast_plane_wr
    import rast_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_we,
    input  logic              pix_copy,
    input  logic              op_raw,
    input  logic              op_deep,
    input  logic [WORD_W-1:0] colour,
    input  logic [C8_W-1:0]   rd8,
    input  logic [C24_W-1:0]  rd24,
    input  logic [WORD_W-1:0] rdctl,
    output logic              we8,
    output logic              we24,
    output logic              wectl,
    output logic [C8_W-1:0]   wd8,
    output logic [C24_W-1:0]  wd24,
    output logic [WORD_W-1:0] wdctl
);
    always_comb begin
        we8   = pix_we;
        we24  = pix_we && op_deep;
        wectl = pix_we && op_deep && op_raw;
        wd8   = pix_copy ? rd8   : colour[C8_W-1:0];
        wd24  = pix_copy ? rd24  : colour[C24_W-1:0];
        wdctl = pix_copy ? rdctl : colour;
    end

    assert_ctl_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wectl |-> (we24 && we8));
endmodule

// File: rtl/rast_engine.sv
module rast_engine
    import rast_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_blit,
    input  logic              wr_raw,
    input  logic              depth24,
    output logic              busy,
    output logic [PIX_AW-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [C8_W-1:0]   mem_rd8,
    input  logic [C24_W-1:0]  mem_rd24,
    input  logic [WORD_W-1:0] mem_rdctl,
    output logic              mem_we8,
    output logic              mem_we24,
    output logic              mem_wectl,
    output logic [C8_W-1:0]   mem_wd8,
    output logic [C24_W-1:0]  mem_wd24,
    output logic [WORD_W-1:0] mem_wdctl
);
    cmd_t              cmd_dec;
    logic              pix_we, pix_copy, op_raw, op_deep;
    logic [WORD_W-1:0] colour;
    logic              wr_fire;

    assign wr_fire = wr_valid && wr_ready;

    rast_cmd_decode u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .blit (wr_blit),
        .raw  (wr_raw),
        .deep (depth24),
        .cmd  (cmd_dec)
    );

    rast_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .wr_trig  (wr_addr[TRIG_BIT]),
        .wr_data  (wr_data),
        .cmd_in   (cmd_dec),
        .ready    (wr_ready),
        .busy     (busy),
        .pix_addr (mem_addr),
        .pix_we   (pix_we),
        .pix_rd   (mem_rd),
        .pix_copy (pix_copy),
        .op_raw   (op_raw),
        .op_deep  (op_deep),
        .colour   (colour)
    );

    rast_plane_wr u_pw (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_we   (pix_we),
        .pix_copy (pix_copy),
        .op_raw   (op_raw),
        .op_deep  (op_deep),
        .colour   (colour),
        .rd8      (mem_rd8),
        .rd24     (mem_rd24),
        .rdctl    (mem_rdctl),
        .we8      (mem_we8),
        .we24     (mem_we24),
        .wectl    (mem_wectl),
        .wd8      (mem_wd8),
        .wd24     (mem_wd24),
        .wdctl    (mem_wdctl)
    );

    assert_write_in_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we8 || mem_rd) |-> busy);

    assert_trigger_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_addr[TRIG_BIT]) |=> busy);

    assert_shallow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wr_addr[TRIG_BIT] && !depth24) |=> !(mem_we24 || mem_wectl));
endmodule

// File: tb/rast_engine_bench.sv
`timescale 1ns/1ps
module rast_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [22:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_blit = 1'b0;
    logic        wr_raw = 1'b0;
    logic        depth24 = 1'b0;
    logic        busy;
    logic [19:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rd8 = '0;
    logic [23:0] mem_rd24 = '0;
    logic [31:0] mem_rdctl = '0;
    logic        mem_we8, mem_we24, mem_wectl;
    logic [7:0]  mem_wd8;
    logic [23:0] mem_wd24;
    logic [31:0] mem_wdctl;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    bit done = 1'b0;
    logic [31:0] cur_colour = '0;

    logic [7:0]  dm8  [int unsigned];
    logic [23:0] dm24 [int unsigned];
    logic [31:0] dmc  [int unsigned];
    logic [7:0]  rf8  [int unsigned];
    logic [23:0] rf24 [int unsigned];
    logic [31:0] rfc  [int unsigned];

    always #4 clk = ~clk;

    rast_engine u_rast_engine (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_blit(wr_blit), .wr_raw(wr_raw),
        .depth24(depth24), .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rd8(mem_rd8), .mem_rd24(mem_rd24), .mem_rdctl(mem_rdctl),
        .mem_we8(mem_we8), .mem_we24(mem_we24), .mem_wectl(mem_wectl),
        .mem_wd8(mem_wd8), .mem_wd24(mem_wd24), .mem_wdctl(mem_wdctl)
    );

    function automatic logic [7:0] gd8(int unsigned a);
        return dm8.exists(a) ? dm8[a] : 8'h0;
    endfunction
    function automatic logic [23:0] gd24(int unsigned a);
        return dm24.exists(a) ? dm24[a] : 24'h0;
    endfunction
    function automatic logic [31:0] gdc(int unsigned a);
        return dmc.exists(a) ? dmc[a] : 32'h0;
    endfunction
    function automatic logic [7:0] gr8(int unsigned a);
        return rf8.exists(a) ? rf8[a] : 8'h0;
    endfunction
    function automatic logic [23:0] gr24(int unsigned a);
        return rf24.exists(a) ? rf24[a] : 24'h0;
    endfunction
    function automatic logic [31:0] grc(int unsigned a);
        return rfc.exists(a) ? rfc[a] : 32'h0;
    endfunction

    // framebuffer model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rd8   <= gd8(int'(mem_addr));
            mem_rd24  <= gd24(int'(mem_addr));
            mem_rdctl <= gdc(int'(mem_addr));
        end
        if (mem_we8)   dm8[int'(mem_addr)]  = mem_wd8;
        if (mem_we24)  dm24[int'(mem_addr)] = mem_wd24;
        if (mem_wectl) dmc[int'(mem_addr)]  = mem_wdctl;
        if (mem_we8)   wcount++;
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    task automatic bus_wr(logic [22:0] a, logic [31:0] d, bit bl, bit rw, output int stalls);
        stalls = 0;
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_blit = bl; wr_raw = rw;
        while (!wr_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic set_colour(logic [31:0] c);
        int s;
        bus_wr({20'($urandom), 3'b000}, c, 1'($urandom), 1'($urandom), s);
        cur_colour = c;
    endtask

    // reference model of one operation
    task automatic ref_op(bit bl, bit rw, bit d24, logic [19:0] dst, logic [31:0] d);
        logic [5:0] len;
        int unsigned di, si;
        len = {1'b0, d[28:24]} + 6'd1;
        if (!bl) begin
            for (int i = 0; i < 32; i++) begin
                di = int'(20'(dst + 20'(i)));
                if (d[31 - i]) begin
                    rf8[di] = cur_colour[7:0];
                    if (d24) rf24[di] = cur_colour[23:0];
                    if (d24 && rw) rfc[di] = cur_colour;
                end
            end
        end else if (d[23:0] == 24'hFFFFFF) begin
            for (int i = 0; i < int'(len); i++) begin
                di = int'(20'(dst + 20'(i)));
                rf8[di] = cur_colour[7:0];
                if (d24) rf24[di] = cur_colour[23:0];
                if (d24 && rw) rfc[di] = cur_colour;
            end
        end else begin
            for (int i = 0; i < int'(len); i++) begin
                di = int'(20'(dst + 20'(i)));
                si = int'(20'(d[19:0] + 20'(i)));
                rf8[di] = gr8(si);
                if (d24) rf24[di] = gr24(si);
                if (d24 && rw) rfc[di] = grc(si);
            end
        end
    endtask

    task automatic cmp_all(string req);
        int bad = 0;
        int unsigned ba = 0;
        longint av = 0, ev = 0;
        for (int k = 0; k < 576; k++) begin
            int unsigned a;
            a = (k < 544) ? k : 32'hFFFE0 + (k - 544);
            if (gd8(a) != gr8(a) || gd24(a) != gr24(a) || gdc(a) != grc(a)) begin
                if (bad == 0) begin
                    ba = a;
                    av = {gdc(a), gd24(a), gd8(a)};
                    ev = {grc(a), gr24(a), gr8(a)};
                end
                bad++;
            end
        end
        chk(bad == 0, req, $sformatf("planes at pixel %0h", ba), av, ev);
    endtask

    function automatic int exp_cycles(bit bl, logic [31:0] d);
        int len = int'(d[28:24]) + 1;
        if (!bl) return 32;
        if (d[23:0] == 24'hFFFFFF) return len;
        return 2 * len;
    endfunction

    task automatic run_op(bit bl, bit rw, bit d24, logic [19:0] dst, logic [31:0] d, string req);
        int s, cnt, w0;
        depth24 = d24;
        ref_op(bl, rw, d24, dst, d);
        w0 = wcount;
        bus_wr({dst, 3'b100}, d, bl, rw, s);
        chk(busy == 1'b1, "R2", "busy after trigger", busy, 1);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == exp_cycles(bl, d), "R11", "busy cycles", cnt, exp_cycles(bl, d));
        if (!bl) chk(wcount - w0 == $countones(d), "R3", "stipple writes", wcount - w0, $countones(d));
        cmp_all(req);
    endtask

    initial begin
        int s, w0;
        logic [31:0] d;
        void'($urandom(32'd2024));
        for (int a = 0; a < 576; a++) begin
            int unsigned ad;
            ad = (a < 544) ? a : 32'hFFFE0 + (a - 544);
            d = $urandom;
            dm8[ad] = d[7:0];   rf8[ad] = d[7:0];
            d = $urandom;
            dm24[ad] = d[23:0]; rf24[ad] = d[23:0];
            d = $urandom;
            dmc[ad] = d;        rfc[ad] = d;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R2", "reset busy", busy, 0);
        chk(wr_ready == 1'b1, "R2", "reset ready", wr_ready, 1);
        chk(mem_we8 == 1'b0, "R2", "reset write enable", mem_we8, 0);

        // R1: colour write alone touches nothing
        w0 = wcount;
        set_colour(32'h02AB_CDEF);
        repeat (3) begin
            chk(busy == 1'b0, "R1", "busy after colour write", busy, 0);
            @(negedge clk);
        end
        chk(wcount == w0, "R1", "writes after colour write", wcount - w0, 0);

        // R3/R8: end bits of the mask, depth 24, plain
        run_op(1'b0, 1'b0, 1'b1, 20'd10, 32'h8000_0001, "R3 R8");
        // R9: raw stipple writes control plane
        set_colour(32'h0155_AA33);
        run_op(1'b0, 1'b1, 1'b1, 20'd60, 32'hF0F0_1234, "R9");
        // R7: depth 8 raw stipple leaves 24 and control planes
        set_colour(32'h03C3_5A7E);
        run_op(1'b0, 1'b1, 1'b0, 20'd100, 32'hFFFF_FFFF, "R7");
        // R5/R4: fills of length 1 and 32
        run_op(1'b1, 1'b1, 1'b1, 20'd140, 32'h00FF_FFFF, "R5 R4");
        run_op(1'b1, 1'b0, 1'b1, 20'd150, 32'hFFFF_FFFF, "R5 R4");
        // R6: forward overlapping copy, raw, depth 24
        run_op(1'b1, 1'b1, 1'b1, 20'd201, 32'hE7_0000C8, "R6");
        // R4: disjoint copy, upper ignored bits set
        run_op(1'b1, 1'b0, 1'b1, 20'd300, 32'hE4_000014, "R4");
        // R10: wrap across pixel 0xFFFFF
        run_op(1'b0, 1'b1, 1'b1, 20'hFFFF0, 32'hFFFF_FFFF, "R10");
        run_op(1'b1, 1'b1, 1'b1, 20'hFFFF8, 32'h1F_0FFFF0, "R10");

        // R2: a write during an operation is stalled
        depth24 = 1'b1;
        ref_op(1'b0, 1'b0, 1'b1, 20'd400, 32'hAAAA_5555);
        bus_wr({20'd400, 3'b100}, 32'hAAAA_5555, 1'b0, 1'b0, s);
        bus_wr(23'h0, 32'h0011_2233, 1'b0, 1'b0, s);
        cur_colour = 32'h0011_2233;
        chk(s > 0, "R2", "stall cycles on write during busy", s, 1);
        cmp_all("R2");
        run_op(1'b0, 1'b0, 1'b1, 20'd440, 32'h0F0F_F0F0, "R2");

        // random mix
        for (int n = 0; n < 40; n++) begin
            bit bl, rw, dp;
            logic [19:0] dst;
            bl = 1'($urandom);
            rw = 1'($urandom);
            dp = 1'($urandom);
            dst = 20'($urandom_range(0, 399));
            if ($urandom_range(0, 3) == 0) set_colour($urandom);
            if (!bl) d = $urandom;
            else if ($urandom_range(0, 3) == 0) d = {8'($urandom), 24'hFFFFFF};
            else d = {8'($urandom), 4'h0, 20'($urandom_range(0, 399))};
            run_op(bl, rw, dp, dst, d, "R3 R4 R5 R6 R7 R8 R9 R11");
        end
        done = 1'b1;
        summary();
    end
endmodule